// File: doc/BRIEF.md
# Block-Addressed Panel Scan Timing Generator

This block derives every scan control strobe for a panel whose rows and columns are driven in groups ("blocks") from a single base clock. Three chained counters track the tick within a column block, the column block within a row block, and the row block within a frame. Registered decodes of those counters produce a frame start pulse, a line start pulse, two complementary shift clock pairs (one for the row side, one for the column side), a one-cycle lock strobe per column block, and a half-rate read clock for the pixel buffer.

Each half-period of a shift clock pair covers exactly one block, so a pair's full period spans two block times. Before every block boundary both members of the pair drop low for one base-clock cycle, which keeps the pair from overlapping. The number of row blocks, column blocks and base-clock ticks per column block are parameters, so the same logic serves full-size panels and small test configurations. The block has no data path; its only inputs are the clock and an active-low reset.

Parameters must satisfy: ROW_BLOCKS and COL_BLOCKS even and at least 2, TICKS_PER_COL at least 2.

Top module: `scan_timing_gen`

## Requirements
- R1: While reset is held, every output is low; on the first clock edge after reset is released the outputs show the start-of-frame state (frame_start and line_start high, all four shift clocks low, lock_pulse low).
- R2: Outputs are registered from the counter state with one cycle of delay: after the n-th rising edge following reset release the outputs reflect state index s = n-1, where tick = s mod T, column block = (s / T) mod C, row block = (s / (T*C)) mod R (T = TICKS_PER_COL, C = COL_BLOCKS, R = ROW_BLOCKS).
- R3: col_ck is high in even-numbered column blocks and col_ckb in odd-numbered column blocks, each except on tick 0 of the block, where both are low (one-cycle non-overlap gap).
- R4: row_ck is high in even-numbered row blocks and row_ckb in odd-numbered row blocks, each except on the first tick of the row block (column block 0, tick 0), where both are low; the two are never high together.
- R5: line_start is high throughout column block 0 of every row block, giving T cycles high in every C*T cycles (ratio 1:C).
- R6: frame_start is high throughout row block 0, giving C*T cycles high in every R*C*T cycles (ratio 1:R); it rises together with line_start.
- R7: lock_pulse is a one-cycle pulse on the last tick (tick T-1) of every column block, and the column pair is in its gap on the following cycle.
- R8: rd_clk_half toggles on every base-clock edge after reset, so it is high after odd edge counts and low after even ones.
- R9: After R row blocks the sequence wraps to row block 0, and the whole pattern repeats every R*C*T cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | output | 1 | High during row block 0 of every frame |
| row_ck | output | 1 | Row shift clock, high in even row blocks |
| row_ckb | output | 1 | Complementary row shift clock, high in odd row blocks |
| line_start | output | 1 | High during column block 0 of every row block |
| col_ck | output | 1 | Column shift clock, high in even column blocks |
| col_ckb | output | 1 | Complementary column shift clock, high in odd column blocks |
| lock_pulse | output | 1 | One-cycle strobe on the last tick of each column block |
| rd_clk_half | output | 1 | Base clock divided by two |

## Verification
The assertions assume the reset is held low across at least one rising edge before release and that the parameters respect the stated constraints (even block counts, at least two ticks per column block), since the alternation and gap properties depend on them. With no other inputs, the bench keeps within these assumptions by holding reset for three edges and elaborating a small even configuration. It then sweeps three complete frames cycle by cycle, comparing every output against an arithmetic decode of the elapsed edge count, which covers every block boundary, both wrap points and the repeat of the frame.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef struct packed {
    logic hi;
    logic lo;
  } clk_pair_t;

  localparam int PAIRS = 2;
  localparam int PAIR_ROW = 0;
  localparam int PAIR_COL = 1;
endpackage

// File: rtl/scan_ctr.sv
module scan_ctr #(
  parameter int LIMIT = 4,
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] count,
  output logic         last
);
  localparam logic [W-1:0] TOP = W'(LIMIT - 1);

  always_comb last = (count == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n)
      count <= '0;
    else if (step)
      count <= last ? '0 : count + 1'b1;
  end

  AST_CTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n) count <= TOP); // R9
  AST_CTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(count)); // R2
endmodule

// File: rtl/scan_pair.sv
module scan_pair (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 odd_block,
  input  logic                 gap,
  output scan_pkg::clk_pair_t  pair
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pair <= '0;
    end else begin
      pair.hi <= !odd_block && !gap;
      pair.lo <= odd_block && !gap;
    end
  end

  AST_PAIR_TURN_HI: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pair.hi) |-> !pair.lo); // R3
  AST_PAIR_TURN_LO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pair.lo) |-> !pair.hi); // R4
endmodule

// File: rtl/scan_timing_gen.sv
module scan_timing_gen #(
  parameter int ROW_BLOCKS    = 90,
  parameter int COL_BLOCKS    = 80,
  parameter int TICKS_PER_COL = 32
) (
  input  logic clk,
  input  logic rst_n,
  output logic frame_start,
  output logic row_ck,
  output logic row_ckb,
  output logic line_start,
  output logic col_ck,
  output logic col_ckb,
  output logic lock_pulse,
  output logic rd_clk_half
);
  import scan_pkg::*;

  localparam int TW = (TICKS_PER_COL > 1) ? $clog2(TICKS_PER_COL) : 1;
  localparam int CW = (COL_BLOCKS > 1) ? $clog2(COL_BLOCKS) : 1;
  localparam int RW = (ROW_BLOCKS > 1) ? $clog2(ROW_BLOCKS) : 1;

  logic [TW-1:0] tick;
  logic [CW-1:0] col;
  logic [RW-1:0] row;
  logic tick_last, col_last, row_last;

  scan_ctr #(.LIMIT(TICKS_PER_COL)) u_tick (
    .clk(clk), .rst_n(rst_n), .step(1'b1), .count(tick), .last(tick_last));
  scan_ctr #(.LIMIT(COL_BLOCKS)) u_col (
    .clk(clk), .rst_n(rst_n), .step(tick_last), .count(col), .last(col_last));
  scan_ctr #(.LIMIT(ROW_BLOCKS)) u_row (
    .clk(clk), .rst_n(rst_n), .step(tick_last && col_last), .count(row),
    .last(row_last));

  logic tick_first, col_first, row_first;
  always_comb begin
    tick_first = (tick == '0);
    col_first  = (col == '0);
    row_first  = (row == '0);
  end

  logic      odd_v [PAIRS];
  logic      gap_v [PAIRS];
  clk_pair_t pair_v[PAIRS];

  always_comb begin
    odd_v[PAIR_ROW] = row[0];
    gap_v[PAIR_ROW] = col_first && tick_first;
    odd_v[PAIR_COL] = col[0];
    gap_v[PAIR_COL] = tick_first;
  end

  for (genvar g = 0; g < PAIRS; g++) begin : g_pair
    scan_pair u_pair (
      .clk(clk), .rst_n(rst_n), .odd_block(odd_v[g]), .gap(gap_v[g]),
      .pair(pair_v[g]));
  end

  always_comb begin
    row_ck  = pair_v[PAIR_ROW].hi;
    row_ckb = pair_v[PAIR_ROW].lo;
    col_ck  = pair_v[PAIR_COL].hi;
    col_ckb = pair_v[PAIR_COL].lo;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_start <= 1'b0;
      line_start  <= 1'b0;
      lock_pulse  <= 1'b0;
      rd_clk_half <= 1'b0;
    end else begin
      frame_start <= row_first;
      line_start  <= col_first;
      lock_pulse  <= tick_last;
      rd_clk_half <= !rd_clk_half;
    end
  end

  logic unused_row_last;
  always_comb unused_row_last = row_last;

  AST_ROW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(row_ck && row_ckb)); // R4
  AST_LOCK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    lock_pulse |=> (!col_ck && !col_ckb)); // R7
  AST_FRAME_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_start) |-> $rose(line_start)); // R6
  AST_HALF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (rd_clk_half != $past(rd_clk_half))); // R8
endmodule

// File: tb/scan_timing_gen_tb.sv
`timescale 1ns/1ps
module scan_timing_gen_tb;
  localparam int R = 4;
  localparam int C = 6;
  localparam int T = 3;
  localparam int FRAME = R * C * T;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start, row_ck, row_ckb, line_start, col_ck, col_ckb;
  logic lock_pulse, rd_clk_half;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  scan_timing_gen #(.ROW_BLOCKS(R), .COL_BLOCKS(C), .TICKS_PER_COL(T)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .row_ck(row_ck),
    .row_ckb(row_ckb), .line_start(line_start), .col_ck(col_ck),
    .col_ckb(col_ckb), .lock_pulse(lock_pulse), .rd_clk_half(rd_clk_half));

  task automatic chk(input string req, input int n, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s edge %0d: actual=%b expected=%b", req, n, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs low under reset
    chk("R1 frame_start", 0, frame_start, 1'b0);
    chk("R1 line_start", 0, line_start, 1'b0);
    chk("R1 row pair", 0, row_ck | row_ckb, 1'b0);
    chk("R1 col pair", 0, col_ck | col_ckb, 1'b0);
    chk("R1 lock", 0, lock_pulse, 1'b0);
    chk("R1 rd_clk_half", 0, rd_clk_half, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int n = 1; n <= 3 * FRAME; n++) begin
      @(posedge clk);
      #1;
      begin
        int s, t, c, r;
        s = n - 1;              // R2: one cycle of output delay
        t = s % T;
        c = (s / T) % C;
        r = (s / (T * C)) % R;  // R9: frame wrap
        chk("R6 frame_start", n, frame_start, r == 0);
        chk("R5 line_start", n, line_start, c == 0);
        chk("R3 col_ck", n, col_ck, (c % 2 == 0) && (t != 0));
        chk("R3 col_ckb", n, col_ckb, (c % 2 == 1) && (t != 0));
        chk("R4 row_ck", n, row_ck, (r % 2 == 0) && !(c == 0 && t == 0));
        chk("R4 row_ckb", n, row_ckb, (r % 2 == 1) && !(c == 0 && t == 0));
        chk("R7 lock_pulse", n, lock_pulse, t == T - 1);
        chk("R8 rd_clk_half", n, rd_clk_half, n % 2 == 1);
        if (n == 1) chk("R1 first edge frame_start", n, frame_start, 1'b1);
        if (n == FRAME + 1) chk("R9 frame restart", n, frame_start & line_start, 1'b1);
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule